// File: doc/BRIEF.md
# Hardware Breakpoint Match Unit

This block watches the instruction fetches and data accesses of a processor core and raises a debug-exception request when one of them hits a breakpoint that software has programmed. It holds four breakpoint address registers, one control register and one status register. All of them sit behind a small select/data register port. Addresses are compared before any translation, so the core feeds the untranslated (linear) address of each access straight into the unit.

The control register gives every breakpoint an enable bit, an access-type field and a length field. The length field covers a 1-, 2- or 4-byte region. The status register collects sticky hit bits, one per breakpoint, plus a single-step bit. Software reads these bits in its debug handler and clears them by writing the register.

The core can also ask for a trap after every retired instruction. It can set a resume flag so that a restarted instruction does not trap again on its own fetch breakpoint. The resume flag drops by itself when that instruction retires.

Top module: `brk_match_unit`

## Requirements
- R1: After reset, every register reads zero and `dbg_req` is low.
- R2: Register select codes are: 0 to 3 for the breakpoint addresses, 4 for control and 5 for status. Any other code reads zero. A write takes effect at the next clock edge. Reads are combinational. Control bits outside the defined fields, and status bits other than 3:0 and 8, read zero.
- R3: The control field for breakpoint i lies in bits 8i+4..8i of the control register. Bit 8i is the enable, bits 8i+2:8i+1 are the access type, and bits 8i+4:8i+3 are the length.
- R4: Access kind is coded 00 fetch, 01 write, 10 read and 11 idle. Type 00 matches fetches only. Type 01 matches writes only. Type 11 matches reads and writes. Type 10 never matches, and neither does access kind 11.
- R5: Length 00 compares every address bit. Length 01 ignores address bit 0. Lengths 10 and 11 ignore address bits 1:0.
- R6: In the cycle after a qualifying access, status bit i is set for every breakpoint i that matched, whether or not that breakpoint is enabled.
- R7: `dbg_req` is high for exactly the one cycle after an access that matched at least one enabled breakpoint.
- R8: When `retire` and `trap_flag` are both high in a cycle, `dbg_req` is high in the next cycle and status bit 8 is set.
- R9: Status bits stay set until software writes the status register. A write replaces the bits, but a hardware set in the same cycle wins.
- R10: A pulse on `resume_set` sets an internal resume flag. While the flag is set, fetch matches neither record status nor request an exception, but data matches still act normally. The flag clears at the edge where `retire` is high, unless `resume_set` is high in the same cycle.
- R11: While `acc_valid` is low, no access is compared: no status bit is set and no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select code |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for the selected code |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_kind | input | 2 | Access kind: 00 fetch, 01 write, 10 read, 11 idle |
| acc_addr | input | 32 | Untranslated access address |
| retire | input | 1 | An instruction retires this cycle |
| trap_flag | input | 1 | Single-step trap enable from the core |
| resume_set | input | 1 | Sets the resume flag for the current instruction |
| dbg_req | output | 1 | Debug-exception request, one-cycle pulse |

## Verification
The bench is a table-driven sweep over access type, length and enable, followed by directed tests for the single-step bit, resume suppression and sticky-status races. Most internal faults show up one cycle after the access that exposes them.

- A wrong type or length decode either misses an expected request or raises a spurious `dbg_req` in the very next cycle. It also leaves the wrong hit bit when status is read back at that point.
- A resume flag that is stuck high or never clears shows as a missing request on the first fetch match after the retiring instruction.
- Lost sticky bits appear on the first status read after idle cycles, or after a write that collides with a hardware set.

// File: rtl/brkm_pkg.sv
package brkm_pkg;

   // access kinds presented by the core
   localparam logic [1:0] KIND_FETCH = 2'b00;
   localparam logic [1:0] KIND_WRITE = 2'b01;
   localparam logic [1:0] KIND_READ  = 2'b10;
   localparam logic [1:0] KIND_IDLE  = 2'b11;

   // breakpoint access-type codes
   localparam logic [1:0] TYP_EXEC = 2'b00;
   localparam logic [1:0] TYP_WR   = 2'b01;
   localparam logic [1:0] TYP_RSVD = 2'b10;
   localparam logic [1:0] TYP_RW   = 2'b11;

   // control field slot per breakpoint in the control register
   localparam int CFG_SLOT = 8;
   // stored bits per breakpoint
   localparam int CFG_W    = 5;
   // status bit carrying the single-step cause
   localparam int STEP_BIT = 8;
   localparam int MAX_BP   = 8;

   typedef struct packed {
      logic [1:0] len;
      logic [1:0] typ;
      logic       en;
   } bp_cfg_t;

endpackage

// File: rtl/brkm_comparator.sv
module brkm_comparator
   import brkm_pkg::*;
#(
   parameter int AW = 32
) (
   input  logic [AW-1:0] bp_addr,
   input  logic [1:0]    typ,
   input  logic [1:0]    len,
   input  logic          acc_valid,
   input  logic [1:0]    acc_kind,
   input  logic [AW-1:0] acc_addr,
   output logic          hit
);

   logic          kind_ok;
   logic [1:0]    low_keep;
   logic [AW-1:0] cmp_mask;
   logic          addr_eq;

   always_comb begin
      unique case (typ)
         TYP_EXEC: kind_ok = (acc_kind == KIND_FETCH);
         TYP_WR:   kind_ok = (acc_kind == KIND_WRITE);
         TYP_RW:   kind_ok = (acc_kind == KIND_WRITE) || (acc_kind == KIND_READ);
         default:  kind_ok = 1'b0;
      endcase
   end

   // length selects how many low address bits take part in the compare
   always_comb begin
      unique case (len)
         2'b00:   low_keep = 2'b11;
         2'b01:   low_keep = 2'b10;
         default: low_keep = 2'b00;
      endcase
   end

   assign cmp_mask = {{(AW-2){1'b1}}, low_keep};
   assign addr_eq  = ((bp_addr ^ acc_addr) & cmp_mask) == '0;
   assign hit      = acc_valid && kind_ok && addr_eq;

endmodule

// File: rtl/brkm_regfile.sv
module brkm_regfile
   import brkm_pkg::*;
#(
   parameter int NUM_BP = 4,
   parameter int XLEN   = 32,
   parameter int SEL_W  = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    reg_we,
   input  logic [SEL_W-1:0]        reg_sel,
   input  logic [XLEN-1:0]         reg_wdata,
   output logic [XLEN-1:0]         reg_rdata,
   input  logic [NUM_BP-1:0]       hw_hits,
   input  logic                    hw_step,
   output logic [NUM_BP*XLEN-1:0]  bp_addr,
   output logic [NUM_BP*CFG_W-1:0] ctrl,
   output logic [NUM_BP-1:0]       stat_hits,
   output logic                    stat_step
);

   localparam logic [SEL_W-1:0] SEL_CTRL = SEL_W'(NUM_BP);
   localparam logic [SEL_W-1:0] SEL_STAT = SEL_W'(NUM_BP + 1);

   logic ctrl_we;
   logic stat_we;

   assign ctrl_we = reg_we && (reg_sel == SEL_CTRL);
   assign stat_we = reg_we && (reg_sel == SEL_STAT);

   for (genvar i = 0; i < NUM_BP; i++) begin : g_bp
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            bp_addr[i*XLEN +: XLEN] <= '0;
            ctrl[i*CFG_W +: CFG_W]  <= '0;
         end else begin
            if (reg_we && (reg_sel == SEL_W'(i)))
               bp_addr[i*XLEN +: XLEN] <= reg_wdata;
            if (ctrl_we)
               ctrl[i*CFG_W +: CFG_W] <= reg_wdata[i*CFG_SLOT +: CFG_W];
         end
      end
   end

   // sticky status: software write replaces, hardware set wins
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_hits <= '0;
         stat_step <= 1'b0;
      end else begin
         stat_hits <= (stat_we ? reg_wdata[NUM_BP-1:0] : stat_hits) | hw_hits;
         stat_step <= (stat_we ? reg_wdata[STEP_BIT]   : stat_step) | hw_step;
      end
   end

   always_comb begin
      reg_rdata = '0;
      for (int i = 0; i < NUM_BP; i++) begin
         if (reg_sel == SEL_W'(i))
            reg_rdata = bp_addr[i*XLEN +: XLEN];
      end
      if (reg_sel == SEL_CTRL) begin
         for (int i = 0; i < NUM_BP; i++)
            reg_rdata[i*CFG_SLOT +: CFG_W] = ctrl[i*CFG_W +: CFG_W];
      end
      if (reg_sel == SEL_STAT) begin
         reg_rdata[NUM_BP-1:0] = stat_hits;
         reg_rdata[STEP_BIT]   = stat_step;
      end
   end

endmodule

// File: rtl/brkm_trap_ctl.sv
module brkm_trap_ctl #(
   parameter int NUM_BP = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_BP-1:0] hits,
   input  logic [NUM_BP-1:0] enables,
   input  logic              is_fetch,
   input  logic              resume_set,
   input  logic              retire,
   input  logic              trap_flag,
   output logic [NUM_BP-1:0] rec_hits,
   output logic              step,
   output logic              dbg_req
);

   logic rf_q;
   logic suppress;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          rf_q <= 1'b0;
      else if (resume_set) rf_q <= 1'b1;
      else if (retire)     rf_q <= 1'b0;
   end

   assign suppress = rf_q && is_fetch;
   assign rec_hits = suppress ? '0 : hits;
   assign step     = retire && trap_flag;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dbg_req <= 1'b0;
      else        dbg_req <= (|(rec_hits & enables)) || step;
   end

   assert_resume_blocks_fetch_R10 : assert property (
      @(posedge clk) disable iff (!rst_n)
      (rf_q && is_fetch && !(retire && trap_flag)) |=> !dbg_req);

   assert_resume_clears_on_retire_R10 : assert property (
      @(posedge clk) disable iff (!rst_n)
      (retire && !resume_set) |=> !rf_q);

endmodule

// File: rtl/brk_match_unit.sv
module brk_match_unit
   import brkm_pkg::*;
#(
   parameter int NUM_BP = 4,
   parameter int XLEN   = 32,
   localparam int SEL_W = $clog2(NUM_BP + 2)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_we,
   input  logic [SEL_W-1:0] reg_sel,
   input  logic [XLEN-1:0]  reg_wdata,
   output logic [XLEN-1:0]  reg_rdata,
   input  logic             acc_valid,
   input  logic [1:0]       acc_kind,
   input  logic [XLEN-1:0]  acc_addr,
   input  logic             retire,
   input  logic             trap_flag,
   input  logic             resume_set,
   output logic             dbg_req
);

   localparam logic [SEL_W-1:0] SEL_STAT = SEL_W'(NUM_BP + 1);

   // elaboration-time parameter checks
   if (NUM_BP < 1 || NUM_BP > MAX_BP) begin : g_bad_num_bp
      $error("brk_match_unit: NUM_BP must lie in 1..8");
   end
   if (XLEN < CFG_SLOT * NUM_BP || XLEN <= STEP_BIT) begin : g_bad_xlen
      $error("brk_match_unit: XLEN too narrow for control and status layout");
   end

   logic [NUM_BP*XLEN-1:0]  bp_addr;
   logic [NUM_BP*CFG_W-1:0] ctrl;
   logic [NUM_BP-1:0]       hits;
   logic [NUM_BP-1:0]       enables;
   logic [NUM_BP-1:0]       rec_hits;
   logic [NUM_BP-1:0]       stat_hits;
   logic                    stat_step;
   logic                    step;
   logic                    is_fetch;
   bp_cfg_t                 cfg [NUM_BP];

   assign is_fetch = acc_valid && (acc_kind == KIND_FETCH);

   brkm_regfile #(
      .NUM_BP (NUM_BP),
      .XLEN   (XLEN),
      .SEL_W  (SEL_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_sel   (reg_sel),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .hw_hits   (rec_hits),
      .hw_step   (step),
      .bp_addr   (bp_addr),
      .ctrl      (ctrl),
      .stat_hits (stat_hits),
      .stat_step (stat_step)
   );

   for (genvar i = 0; i < NUM_BP; i++) begin : g_cmp
      assign cfg[i]     = bp_cfg_t'(ctrl[i*CFG_W +: CFG_W]);
      assign enables[i] = cfg[i].en;

      brkm_comparator #(
         .AW (XLEN)
      ) u_cmp (
         .bp_addr   (bp_addr[i*XLEN +: XLEN]),
         .typ       (cfg[i].typ),
         .len       (cfg[i].len),
         .acc_valid (acc_valid),
         .acc_kind  (acc_kind),
         .acc_addr  (acc_addr),
         .hit       (hits[i])
      );

      assert_reserved_type_silent_R4 : assert property (
         @(posedge clk) disable iff (!rst_n)
         (cfg[i].typ == TYP_RSVD) |-> !hits[i]);
   end

   brkm_trap_ctl #(
      .NUM_BP (NUM_BP)
   ) u_trap (
      .clk        (clk),
      .rst_n      (rst_n),
      .hits       (hits),
      .enables    (enables),
      .is_fetch   (is_fetch),
      .resume_set (resume_set),
      .retire     (retire),
      .trap_flag  (trap_flag),
      .rec_hits   (rec_hits),
      .step       (step),
      .dbg_req    (dbg_req)
   );

   assert_status_sticky_R9 : assert property (
      @(posedge clk) disable iff (!rst_n)
      !(reg_we && reg_sel == SEL_STAT) |=>
         ((stat_hits & $past(stat_hits)) == $past(stat_hits)));

   assert_step_traps_R8 : assert property (
      @(posedge clk) disable iff (!rst_n)
      (retire && trap_flag) |=> (dbg_req && stat_step));

   assert_req_has_cause_R7 : assert property (
      @(posedge clk) disable iff (!rst_n)
      dbg_req |-> $past(acc_valid || (retire && trap_flag)));

   assert_no_access_no_record_R11 : assert property (
      @(posedge clk) disable iff (!rst_n)
      (!acc_valid && !reg_we) |=> (stat_hits == $past(stat_hits)));

endmodule

// File: tb/tb_brk_match_unit.sv
module tb_brk_match_unit;

   localparam int CLK_PERIOD = 10;
   localparam int NV = 17;

   // {ctrl[75:44], kind[43:42], addr[41:10], req[9], status[8:0]}
   localparam logic [75:0] VEC [NV] = '{
      {32'h0000_0001, 2'b00, 32'h0000_1000, 1'b1, 9'h001},  // exec hit
      {32'h0000_0001, 2'b00, 32'h0000_1001, 1'b0, 9'h000},  // 1-byte miss
      {32'h0000_0000, 2'b00, 32'h0000_1000, 1'b0, 9'h001},  // disabled, recorded
      {32'h0000_0003, 2'b01, 32'h0000_1000, 1'b1, 9'h001},  // write type, write
      {32'h0000_0003, 2'b10, 32'h0000_1000, 1'b0, 9'h000},  // write type, read
      {32'h0000_0003, 2'b00, 32'h0000_1000, 1'b0, 9'h000},  // write type, fetch
      {32'h0000_0007, 2'b10, 32'h0000_1000, 1'b1, 9'h001},  // rw type, read
      {32'h0000_0007, 2'b01, 32'h0000_1000, 1'b1, 9'h001},  // rw type, write
      {32'h0000_0005, 2'b01, 32'h0000_1000, 1'b0, 9'h000},  // reserved type
      {32'h0000_0005, 2'b10, 32'h0000_1000, 1'b0, 9'h000},  // reserved type
      {32'h0000_0B00, 2'b01, 32'h0000_2003, 1'b1, 9'h002},  // 2-byte hit
      {32'h0000_0B00, 2'b01, 32'h0000_2001, 1'b0, 9'h000},  // 2-byte miss
      {32'h001F_0000, 2'b10, 32'h0000_3007, 1'b1, 9'h004},  // 4-byte hit
      {32'h001F_0000, 2'b10, 32'h0000_3008, 1'b0, 9'h000},  // 4-byte miss
      {32'h1100_0000, 2'b00, 32'h0000_400B, 1'b1, 9'h008},  // len 10 as 4-byte
      {32'h0101_0101, 2'b00, 32'h0000_2002, 1'b1, 9'h002},  // all enabled
      {32'h0000_0007, 2'b11, 32'h0000_1000, 1'b0, 9'h000}   // idle kind
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_sel = 3'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        acc_valid = 1'b0;
   logic [1:0]  acc_kind = 2'b11;
   logic [31:0] acc_addr = '0;
   logic        retire = 1'b0;
   logic        trap_flag = 1'b0;
   logic        resume_set = 1'b0;
   logic        dbg_req;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   brk_match_unit dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_we     (reg_we),
      .reg_sel    (reg_sel),
      .reg_wdata  (reg_wdata),
      .reg_rdata  (reg_rdata),
      .acc_valid  (acc_valid),
      .acc_kind   (acc_kind),
      .acc_addr   (acc_addr),
      .retire     (retire),
      .trap_flag  (trap_flag),
      .resume_set (resume_set),
      .dbg_req    (dbg_req)
   );

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %h exp %h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [2:0] sel, input logic [31:0] data);
      @(negedge clk);
      reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd_chk(input string tag, input logic [2:0] sel, input logic [31:0] exp);
      reg_sel = sel;
      #1;
      check(tag, reg_rdata, exp);
   endtask

   task automatic access(input logic [1:0] kind, input logic [31:0] addr);
      @(negedge clk);
      acc_valid = 1'b1; acc_kind = kind; acc_addr = addr;
      @(negedge clk);
      acc_valid = 1'b0; acc_kind = 2'b11;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 50000);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 dbg_req", {31'd0, dbg_req}, 32'd0);
      for (int s = 0; s < 6; s++) rd_chk("R1 reg", 3'(s), 32'd0);

      // R2 register port
      wr(3'd0, 32'h0000_1000);
      wr(3'd1, 32'h0000_2002);
      wr(3'd2, 32'h0000_3004);
      wr(3'd3, 32'h0000_4008);
      rd_chk("R2 addr0", 3'd0, 32'h0000_1000);
      rd_chk("R2 addr3", 3'd3, 32'h0000_4008);
      wr(3'd4, 32'hFFFF_FFFF);
      rd_chk("R2 R3 ctrl fields", 3'd4, 32'h1F1F_1F1F);
      rd_chk("R2 unused sel", 3'd7, 32'd0);
      wr(3'd4, 32'h0);
      wr(3'd5, 32'hFFFF_FFFF);
      rd_chk("R2 status bits", 3'd5, 32'h0000_010F);
      wr(3'd5, 32'h0);

      // R3 R4 R5 R6 R7 vector sweep
      for (int v = 0; v < NV; v++) begin
         wr(3'd4, VEC[v][75:44]);
         wr(3'd5, 32'h0);
         access(VEC[v][43:42], VEC[v][41:10]);
         check($sformatf("R7 req vec %0d", v), {31'd0, dbg_req}, {31'd0, VEC[v][9]});
         rd_chk($sformatf("R4 R5 R6 status vec %0d", v), 3'd5, {23'd0, VEC[v][8:0]});
         if (v == 0) begin
            @(negedge clk);
            check("R7 one-cycle pulse", {31'd0, dbg_req}, 32'd0);
         end
      end

      // R11 no compare without acc_valid
      wr(3'd4, 32'h1);
      wr(3'd5, 32'h0);
      @(negedge clk);
      acc_kind = 2'b00; acc_addr = 32'h1000;
      @(negedge clk);
      acc_kind = 2'b11;
      check("R11 req", {31'd0, dbg_req}, 32'd0);
      rd_chk("R11 status", 3'd5, 32'd0);

      // R9 sticky across idle cycles, cleared by write
      access(2'b00, 32'h1000);
      repeat (3) @(negedge clk);
      rd_chk("R9 sticky", 3'd5, 32'h1);
      wr(3'd5, 32'h0);
      rd_chk("R9 cleared", 3'd5, 32'h0);
      // R9 hardware set beats simultaneous clearing write
      @(negedge clk);
      acc_valid = 1'b1; acc_kind = 2'b00; acc_addr = 32'h1000;
      reg_we = 1'b1; reg_sel = 3'd5; reg_wdata = 32'h0;
      @(negedge clk);
      acc_valid = 1'b0; acc_kind = 2'b11; reg_we = 1'b0;
      rd_chk("R9 set wins", 3'd5, 32'h1);
      wr(3'd5, 32'h0);

      // R8 single step
      @(negedge clk);
      retire = 1'b1;
      @(negedge clk);
      retire = 1'b0;
      check("R8 retire w/o trap", {31'd0, dbg_req}, 32'd0);
      @(negedge clk);
      retire = 1'b1; trap_flag = 1'b1;
      @(negedge clk);
      retire = 1'b0; trap_flag = 1'b0;
      check("R8 step req", {31'd0, dbg_req}, 32'd1);
      rd_chk("R8 step status", 3'd5, 32'h100);
      wr(3'd5, 32'h0);

      // R10 resume flag
      @(negedge clk);
      resume_set = 1'b1;
      @(negedge clk);
      resume_set = 1'b0;
      access(2'b00, 32'h1000);
      check("R10 fetch suppressed", {31'd0, dbg_req}, 32'd0);
      rd_chk("R10 no record", 3'd5, 32'h0);
      access(2'b00, 32'h1000);
      check("R10 still suppressed", {31'd0, dbg_req}, 32'd0);
      wr(3'd4, 32'h3);
      access(2'b01, 32'h1000);
      check("R10 data not suppressed", {31'd0, dbg_req}, 32'd1);
      rd_chk("R10 data recorded", 3'd5, 32'h1);
      wr(3'd5, 32'h0);
      wr(3'd4, 32'h1);
      @(negedge clk);
      retire = 1'b1;
      @(negedge clk);
      retire = 1'b0;
      access(2'b00, 32'h1000);
      check("R10 cleared by retire", {31'd0, dbg_req}, 32'd1);
      rd_chk("R10 status after retire", 3'd5, 32'h1);

      // R6 R7 two matches, one enabled
      wr(3'd1, 32'h0000_1000);
      wr(3'd5, 32'h0);
      access(2'b00, 32'h1000);
      check("R7 multi req", {31'd0, dbg_req}, 32'd1);
      rd_chk("R6 multi status", 3'd5, 32'h3);
      wr(3'd4, 32'h0);
      wr(3'd5, 32'h0);
      access(2'b00, 32'h1000);
      check("R7 none enabled", {31'd0, dbg_req}, 32'd0);
      rd_chk("R6 none enabled status", 3'd5, 32'h3);

      // R1 reset mid-run clears everything
      wr(3'd4, 32'h1);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      rd_chk("R1 ctrl after reset", 3'd4, 32'd0);
      rd_chk("R1 addr after reset", 3'd0, 32'd0);
      rd_chk("R1 status after reset", 3'd5, 32'd0);

      finish_run();
   end

endmodule